// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block sits between instruction issue and decode and turns one scalar instruction into a run of element operations. When an instruction is accepted, the block holds the main program counter. It then walks a source element index and a destination element index across the vector. Each issued pair becomes two 7-bit register numbers, formed by adding each index to its base register number. Source and destination each have their own predicate mask, and each mask can be used inverted. Every cycle the block picks the next enabled source position and the next enabled destination position and issues them together. Masked-off positions therefore cost no cycles. This lets one instruction compress, expand, or pair elements in a gather/scatter style.

The block loads its loop state (vector length, masks, and both step counters) from configuration inputs when it accepts an instruction. It reports the live vector length and step values so software can save them. An interrupt request stops the loop between two element steps and leaves the counters on the next unissued pair, so re-issuing with those counters resumes the loop with the same results. In data-dependent fail-first mode, a failing condition test on an issued element ends the loop and shortens the vector length at that point.

Top module: `elem_loop_seq`

## Requirements
- R1: While reset is active and after reset is released, pc_hold, elem_vld, loop_done and loop_paused are 0, and st_vl, st_src_step and st_dst_step are 0.
- R2: insn_vld in an idle cycle captures every cfg_* input and the two bases, and raises pc_hold in that cycle. pc_hold stays 1 in every following cycle until the finishing cycle (loop_done or loop_paused), where it is 0. insn_vld while a loop runs is ignored.
- R3: On every element strobe, elem_src_reg = (src_base + source index) mod 128 and elem_dst_reg = (dst_base + destination index) mod 128, both 7 bits wide.
- R4: The loop issues at most one pair per cycle, starting in the cycle after acceptance. The source index takes, in ascending order, each position p with starting step <= p < vl whose effective source mask bit is 1. The destination index does the same, independently, with its own step and mask. Mask bit p belongs to element position p.
- R5: When the inversion bit of a side is 1, the effective mask of that side is the bitwise complement of its mask input. Otherwise it is the mask itself.
- R6: In a running cycle where either side has no enabled position left below vl, loop_done is 1 and there is no strobe. The loop then goes idle, both steps reset to 0, and st_vl keeps vl. A vector length of 0 therefore finishes in the first running cycle with no strobe.
- R7: With cfg_ff_en = 1, cond_fail = 1 in a strobe cycle raises loop_done in that same cycle. st_vl becomes the destination index plus 1 when cfg_ff_incl = 1, or the destination index alone when cfg_ff_incl = 0. With cfg_ff_en = 0, cond_fail has no effect.
- R8: irq_req in a running cycle that still has a pair to issue produces no strobe and raises loop_paused. The loop goes idle with st_src_step and st_dst_step equal to that pair's positions.
- R9: With vl = 1, both masks all ones, no inversion and both steps 0, exactly one strobe is issued, carrying the two base register numbers, and loop_done follows in the next cycle.
- R10: Non-zero starting steps take effect: positions below a side's starting step are never issued. Re-issuing after a pause with the saved steps yields exactly the pairs the pause held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | Instruction offered for looping |
| src_base | input | 7 | Source base register number |
| dst_base | input | 7 | Destination base register number |
| cfg_vl | input | SW | Vector length |
| cfg_src_mask | input | MAXVL | Source predicate mask |
| cfg_src_inv | input | 1 | Use complement of source mask |
| cfg_dst_mask | input | MAXVL | Destination predicate mask |
| cfg_dst_inv | input | 1 | Use complement of destination mask |
| cfg_src_step | input | SW | Starting source step |
| cfg_dst_step | input | SW | Starting destination step |
| cfg_ff_en | input | 1 | Enable data-dependent fail-first |
| cfg_ff_incl | input | 1 | Failing element counts in new length |
| cond_fail | input | 1 | Condition test failed for the current strobe |
| irq_req | input | 1 | Interrupt request |
| pc_hold | output | 1 | Main program counter must not advance |
| elem_vld | output | 1 | Element issue strobe |
| elem_src_reg | output | 7 | Source register number of this element |
| elem_dst_reg | output | 7 | Destination register number of this element |
| loop_done | output | 1 | Loop finishes this cycle |
| loop_paused | output | 1 | Loop stopped for an interrupt this cycle |
| st_vl | output | SW | Current vector length |
| st_src_step | output | SW | Current source step |
| st_dst_step | output | SW | Current destination step |

## Verification
The main function is swept over every vector length from 0 to 8 combined with every source mask, and over every destination mask with each inversion setting. These sweeps distinguish mask skipping, termination on either side, and the inversion path. Separate runs use wrapped base numbers and a grid of non-zero starting steps, which show that the index adds onto the base and that positions below the start are excluded. Fail-first is tried at several strobe positions, with the include bit both set and clear and with the mode disabled. This separates the new length from the loop end and confirms that cond_fail is ignored when the mode is off. Interrupts are placed at every cycle of a run, and each paused run is resumed from the saved steps. The strobe count across the paused run and the resumed run must equal the count of an uninterrupted run.

// File: rtl/els_pkg.sv
`timescale 1ns/1ps
package els_pkg;
  localparam int unsigned ELS_REGW = 7;
  typedef logic [ELS_REGW-1:0] els_reg_t;
  typedef enum logic {ELS_IDLE = 1'b0, ELS_RUN = 1'b1} els_mode_e;
endpackage

// File: rtl/els_pick.sv
`timescale 1ns/1ps
// Finds the lowest enabled position at or above 'from' and below 'limit'.
module els_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned SW = 4
) (
  input  logic [N-1:0]  mask,
  input  logic          inv,
  input  logic [SW-1:0] from,
  input  logic [SW-1:0] limit,
  output logic          hit,
  output logic [SW-1:0] pos
);
  logic [N-1:0] eff;

  always_comb begin
    eff = mask ^ {N{inv}};
    hit = 1'b0;
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eff[i] && (SW'(i) >= from) && (SW'(i) < limit)) begin
        hit = 1'b1;
        pos = SW'(i);
      end
    end
  end
endmodule

// File: rtl/els_regcalc.sv
`timescale 1ns/1ps
// Register number = base + element index, wrapping in the register space.
module els_regcalc
  import els_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  els_reg_t      base,
  input  logic [SW-1:0] idx,
  output els_reg_t      num
);
  assign num = base + els_reg_t'(idx);
endmodule

// File: rtl/elem_loop_seq.sv
`timescale 1ns/1ps
module elem_loop_seq
  import els_pkg::*;
#(
  parameter int unsigned MAXVL = 8,
  localparam int unsigned SW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_vld,
  input  logic [6:0]       src_base,
  input  logic [6:0]       dst_base,
  input  logic [SW-1:0]    cfg_vl,
  input  logic [MAXVL-1:0] cfg_src_mask,
  input  logic             cfg_src_inv,
  input  logic [MAXVL-1:0] cfg_dst_mask,
  input  logic             cfg_dst_inv,
  input  logic [SW-1:0]    cfg_src_step,
  input  logic [SW-1:0]    cfg_dst_step,
  input  logic             cfg_ff_en,
  input  logic             cfg_ff_incl,
  input  logic             cond_fail,
  input  logic             irq_req,
  output logic             pc_hold,
  output logic             elem_vld,
  output logic [6:0]       elem_src_reg,
  output logic [6:0]       elem_dst_reg,
  output logic             loop_done,
  output logic             loop_paused,
  output logic [SW-1:0]    st_vl,
  output logic [SW-1:0]    st_src_step,
  output logic [SW-1:0]    st_dst_step
);
  localparam int unsigned NSIDE = 2; // index 0 = source, 1 = destination

  // State registers
  els_mode_e                          mode_q, mode_d;
  logic [SW-1:0]                      vl_q, vl_d;
  logic [NSIDE-1:0][SW-1:0]           step_q, step_d;
  logic [NSIDE-1:0][MAXVL-1:0]        mask_q, mask_d;
  logic [NSIDE-1:0]                   inv_q, inv_d;
  logic [NSIDE-1:0][ELS_REGW-1:0]     base_q, base_d;
  logic                               ffen_q, ffen_d;
  logic                               ffincl_q, ffincl_d;

  // Per-side datapath
  logic [NSIDE-1:0]                   hit;
  logic [NSIDE-1:0][SW-1:0]           pos;
  logic [NSIDE-1:0][ELS_REGW-1:0]     regnum;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    els_pick #(.N(MAXVL), .SW(SW)) u_pick (
      .mask  (mask_q[g]),
      .inv   (inv_q[g]),
      .from  (step_q[g]),
      .limit (vl_q),
      .hit   (hit[g]),
      .pos   (pos[g])
    );
    els_regcalc #(.SW(SW)) u_reg (
      .base (base_q[g]),
      .idx  (pos[g]),
      .num  (regnum[g])
    );
  end

  // Control decode
  logic running, have_pair, issue, ff_stop, end_empty, accept, clk_en;

  always_comb begin
    running   = (mode_q == ELS_RUN);
    have_pair = &hit;
    end_empty = running & ~have_pair;
    issue     = running & have_pair & ~irq_req;
    ff_stop   = issue & ffen_q & cond_fail;
    accept    = ~running & insn_vld;
    clk_en    = accept | running;
  end

  assign elem_vld     = issue;
  assign loop_done    = end_empty | ff_stop;
  assign loop_paused  = running & have_pair & irq_req;
  assign pc_hold      = accept | (running & ~loop_done & ~loop_paused);
  assign elem_src_reg = regnum[0];
  assign elem_dst_reg = regnum[1];
  assign st_vl        = vl_q;
  assign st_src_step  = step_q[0];
  assign st_dst_step  = step_q[1];

  // Next state
  always_comb begin
    mode_d   = mode_q;
    vl_d     = vl_q;
    step_d   = step_q;
    mask_d   = mask_q;
    inv_d    = inv_q;
    base_d   = base_q;
    ffen_d   = ffen_q;
    ffincl_d = ffincl_q;
    if (accept) begin
      mode_d    = ELS_RUN;
      vl_d      = cfg_vl;
      step_d[0] = cfg_src_step;
      step_d[1] = cfg_dst_step;
      mask_d[0] = cfg_src_mask;
      mask_d[1] = cfg_dst_mask;
      inv_d     = {cfg_dst_inv, cfg_src_inv};
      base_d[0] = src_base;
      base_d[1] = dst_base;
      ffen_d    = cfg_ff_en;
      ffincl_d  = cfg_ff_incl;
    end else if (running) begin
      if (loop_done) begin
        mode_d = ELS_IDLE;
        step_d = '0;
        if (ff_stop) vl_d = pos[1] + SW'(ffincl_q);
      end else if (loop_paused) begin
        mode_d = ELS_IDLE;
        step_d = pos;
      end else begin
        for (int g = 0; g < NSIDE; g++) step_d[g] = pos[g] + SW'(1);
      end
    end
  end

  // Registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= ELS_IDLE;
      vl_q     <= '0;
      step_q   <= '0;
      mask_q   <= '0;
      inv_q    <= '0;
      base_q   <= '0;
      ffen_q   <= 1'b0;
      ffincl_q <= 1'b0;
    end else if (clk_en) begin
      mode_q   <= mode_d;
      vl_q     <= vl_d;
      step_q   <= step_d;
      mask_q   <= mask_d;
      inv_q    <= inv_d;
      base_q   <= base_d;
      ffen_q   <= ffen_d;
      ffincl_q <= ffincl_d;
    end
  end

  // Assertions
  a_r2_start_needs_insn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ELS_RUN && $past(mode_q) == ELS_IDLE) |-> $past(insn_vld));

  a_r4_pick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    elem_vld |-> (pos[0] < vl_q && pos[1] < vl_q));

  a_r4_steps_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld && !loop_done) |=> (st_src_step > $past(st_src_step)) &&
                                 (st_dst_step > $past(st_dst_step)));

  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !elem_vld);

  a_r7_ff_shortens: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld && loop_done) |=> (st_vl <= $past(vl_q)));

  a_r8_pause_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    loop_paused |-> (!elem_vld && !loop_done));
endmodule

// File: tb/elem_loop_seq_test.sv
`timescale 1ns/1ps
module elem_loop_seq_test;
  localparam int MAXVL = 8;
  localparam int SW = 4;

  logic clk, rst_n, insn_vld;
  logic [6:0] src_base, dst_base;
  logic [SW-1:0] cfg_vl, cfg_src_step, cfg_dst_step;
  logic [MAXVL-1:0] cfg_src_mask, cfg_dst_mask;
  logic cfg_src_inv, cfg_dst_inv, cfg_ff_en, cfg_ff_incl, cond_fail, irq_req;
  logic pc_hold, elem_vld, loop_done, loop_paused;
  logic [6:0] elem_src_reg, elem_dst_reg;
  logic [SW-1:0] st_vl, st_src_step, st_dst_step;

  int checks = 0;
  int errors = 0;

  elem_loop_seq #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld),
    .src_base(src_base), .dst_base(dst_base), .cfg_vl(cfg_vl),
    .cfg_src_mask(cfg_src_mask), .cfg_src_inv(cfg_src_inv),
    .cfg_dst_mask(cfg_dst_mask), .cfg_dst_inv(cfg_dst_inv),
    .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_ff_en(cfg_ff_en), .cfg_ff_incl(cfg_ff_incl),
    .cond_fail(cond_fail), .irq_req(irq_req),
    .pc_hold(pc_hold), .elem_vld(elem_vld),
    .elem_src_reg(elem_src_reg), .elem_dst_reg(elem_dst_reg),
    .loop_done(loop_done), .loop_paused(loop_paused),
    .st_vl(st_vl), .st_src_step(st_src_step), .st_dst_step(st_dst_step)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find_pos(input logic [7:0] m, input logic inv,
                                  input int from, input int lim);
    for (int i = from; i < 8; i++)
      if (i < lim && (m[i] ^ inv)) return i;
    return -1;
  endfunction

  task automatic run_one(input int vl, input logic [7:0] sm, input logic si,
                         input logic [7:0] dm, input logic di,
                         input int s0, input int d0,
                         input logic ff, input logic incl, input int fail_at,
                         input int irq_at, input logic noisy,
                         input logic [6:0] sb, input logic [6:0] db,
                         output int nstrobes);
    int s, d, sn, dn, cyc, exp_vl, es, ed;
    bit fin;
    @(negedge clk);
    cfg_vl = SW'(vl); cfg_src_mask = sm; cfg_src_inv = si;
    cfg_dst_mask = dm; cfg_dst_inv = di;
    cfg_src_step = SW'(s0); cfg_dst_step = SW'(d0);
    cfg_ff_en = ff; cfg_ff_incl = incl; src_base = sb; dst_base = db;
    insn_vld = 1'b1; irq_req = 1'b0; cond_fail = 1'b0;
    #1;
    chk(pc_hold === 1'b1, "R2", "pc_hold on accept", int'(pc_hold), 1);
    s = s0; d = d0; exp_vl = vl; es = 0; ed = 0; cyc = 0; fin = 0; nstrobes = 0;
    while (!fin && cyc < 40) begin
      @(negedge clk);
      insn_vld = noisy;
      if (noisy) begin src_base = sb + 7'd33; cfg_vl = SW'(1); end
      irq_req = (cyc == irq_at);
      cond_fail = (nstrobes == fail_at);
      sn = find_pos(sm, si, s, vl);
      dn = find_pos(dm, di, d, vl);
      #1;
      if (sn < 0 || dn < 0) begin
        chk(loop_done === 1'b1 && elem_vld === 1'b0, "R6", "done with no strobe",
            int'({loop_done, elem_vld}), 2);
        chk(pc_hold === 1'b0, "R2", "pc_hold on finish", int'(pc_hold), 0);
        fin = 1;
      end else if (cyc == irq_at) begin
        chk(loop_paused === 1'b1 && elem_vld === 1'b0, "R8", "pause without strobe",
            int'({loop_paused, elem_vld}), 2);
        es = sn; ed = dn; fin = 1;
      end else begin
        chk(elem_vld === 1'b1, "R4", "strobe expected", int'(elem_vld), 1);
        chk(elem_src_reg === 7'(sb + 7'(sn)), "R3", "source register",
            int'(elem_src_reg), int'(7'(sb + 7'(sn))));
        chk(elem_dst_reg === 7'(db + 7'(dn)), "R3", "destination register",
            int'(elem_dst_reg), int'(7'(db + 7'(dn))));
        nstrobes++;
        if (ff && nstrobes - 1 == fail_at) begin
          chk(loop_done === 1'b1, "R7", "fail-first ends loop", int'(loop_done), 1);
          exp_vl = dn + int'(incl); fin = 1;
        end else begin
          chk(loop_done === 1'b0 && pc_hold === 1'b1, "R2", "hold while running",
              int'({loop_done, pc_hold}), 1);
          s = sn + 1; d = dn + 1;
        end
      end
      cyc++;
    end
    if (!fin) chk(0, "R6", "loop never finished", cyc, 0);
    @(negedge clk);
    insn_vld = 1'b0; irq_req = 1'b0; cond_fail = 1'b0; src_base = sb;
    #1;
    chk(st_vl === SW'(exp_vl), (ff ? "R7" : "R6"), "state vector length",
        int'(st_vl), exp_vl);
    chk(st_src_step === SW'(es) && st_dst_step === SW'(ed), "R8",
        "state steps after finish", int'({st_src_step, st_dst_step}),
        int'({SW'(es), SW'(ed)}));
    chk(elem_vld === 1'b0 && pc_hold === 1'b0, "R6", "idle after finish",
        int'({elem_vld, pc_hold}), 0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, n1, n2, full;
    logic [6:0] ss, sd;
    rst_n = 1'b0; insn_vld = 1'b0; src_base = '0; dst_base = '0;
    cfg_vl = '0; cfg_src_mask = '0; cfg_dst_mask = '0; cfg_src_inv = 1'b0;
    cfg_dst_inv = 1'b0; cfg_src_step = '0; cfg_dst_step = '0;
    cfg_ff_en = 1'b0; cfg_ff_incl = 1'b0; cond_fail = 1'b0; irq_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(pc_hold === 0 && elem_vld === 0 && loop_done === 0 && loop_paused === 0,
        "R1", "outputs in reset", int'({pc_hold, elem_vld, loop_done, loop_paused}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(st_vl === 0 && st_src_step === 0 && st_dst_step === 0, "R1",
        "state after reset", int'({st_vl, st_src_step, st_dst_step}), 0);

    // R9: scalar equivalence
    run_one(1, 8'hff, 0, 8'hff, 0, 0, 0, 0, 0, -1, -1, 0, 7'd5, 7'd9, n);
    chk(n == 1, "R9", "single strobe", n, 1);

    // R6: zero length
    run_one(0, 8'hff, 0, 8'hff, 0, 0, 0, 0, 0, -1, -1, 0, 7'd1, 7'd2, n);
    chk(n == 0, "R6", "no strobe at vl 0", n, 0);

    // R3: wrap-around of register numbers
    run_one(8, 8'hff, 0, 8'hff, 0, 0, 0, 0, 0, -1, -1, 0, 7'd126, 7'd123, n);
    chk(n == 8, "R3", "strobes with wrapping bases", n, 8);

    // R2: insn_vld while running is ignored
    run_one(6, 8'hff, 0, 8'hff, 0, 0, 0, 0, 0, -1, -1, 1, 7'd40, 7'd60, n);
    chk(n == 6, "R2", "strobes despite new offers", n, 6);

    // R4: source mask sweep over all vector lengths
    for (int vl = 0; vl <= 8; vl++)
      for (int m = 0; m < 256; m++)
        run_one(vl, 8'(m), 0, 8'hff, 0, 0, 0, 0, 0, -1, -1, 0, 7'(m), 7'd64, n);

    // R5: destination mask sweep with both inversion settings
    for (int vl = 5; vl <= 8; vl += 3)
      for (int inv = 0; inv < 2; inv++)
        for (int m = 0; m < 256; m++)
          run_one(vl, {8'(m)} ^ 8'h5a, 1'(inv), 8'(m), 1'(inv), 0, 0, 0, 0, -1, -1, 0,
                  7'd10, 7'(m), n);

    // R10: starting steps
    for (int s0 = 0; s0 <= 8; s0++)
      for (int d0 = 0; d0 <= 8; d0++)
        run_one(8, 8'hb5, 0, 8'h6e, 0, s0, d0, 0, 0, -1, -1, 0, 7'd20, 7'd100, n);

    // R7: fail-first positions, include/exclude, and disabled mode
    for (int fa = 0; fa < 5; fa++)
      for (int inc = 0; inc < 2; inc++)
        run_one(8, 8'hdb, 0, 8'h7f, 0, 0, 0, 1, 1'(inc), fa, -1, 0, 7'd3, 7'd30, n);
    run_one(8, 8'hdb, 0, 8'h7f, 0, 0, 0, 0, 1, 1, -1, 0, 7'd3, 7'd30, n);
    chk(n == 6, "R7", "cond_fail ignored when disabled", n, 6);

    // R8/R10: interrupt at each cycle and resume from saved steps
    run_one(8, 8'hed, 0, 8'hbf, 0, 0, 0, 0, 0, -1, -1, 0, 7'd8, 7'd70, full);
    for (int ia = 0; ia < 8; ia++) begin
      run_one(8, 8'hed, 0, 8'hbf, 0, 0, 0, 0, 0, -1, ia, 0, 7'd8, 7'd70, n1);
      ss = 7'(st_src_step); sd = 7'(st_dst_step);
      if (n1 < full) begin
        run_one(8, 8'hed, 0, 8'hbf, 0, int'(ss), int'(sd), 0, 0, -1, -1, 0,
                7'd8, 7'd70, n2);
        chk(n1 + n2 == full, "R10", "resume completes the loop", n1 + n2, full);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule